// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

This block keeps the receive and transmit statistics of a small multi-port Ethernet switch. Each port's MAC reports one receive and one transmit event per clock at most. An event carries a frame class, a size bin, a set of error or collision flags and a byte count. For every port the block keeps single-word event counters and three double-word byte totals. Software reads all of them through a 32-bit register window, one window per port.

Two global registers sit beside the windows. The first is a module-enable word whose bit 0 gates all counting. The second is a control word. Writing it with both the flush bit and the busy bit set starts a clear that walks the counter words one per clock. The busy bit stays high for the whole walk and then drops by itself. Events that arrive during a flush are dropped. Counters saturate instead of wrapping.

Top module: `stat_counter_bank`

## Requirements
- R1: Port p (0..NUM_PORTS-1) word k (0..43) is read at address 0x1000 + 0x100*p + 4*k. Words 42 and 43, ports at or above NUM_PORTS, misaligned addresses and any other unmapped address read as zero. A read issued with reg_rd appears on reg_rdata in the next cycle, and reg_rdata holds its value while no read is issued.
- R2: A receive event increments these words. By class (rx_cls): 1 (broadcast) gives word 0, 3 (pause) gives word 1, 2 (multicast) gives word 2, and 0 (unicast) counts no class word. By error bit (rx_err): bits 0 to 3 (FCS, alignment, runt, fragment) give words 3 to 6, bit 4 (too long) gives word 14, bit 5 (overflow) gives word 19, and bit 6 (filtered) gives word 20. By size bin (rx_bin): codes 0 to 5 give words 7 to 12, code 6 (max size) gives word 13, and code 7 counts no bin.
- R3: A transmit event increments these words. By class (tx_cls): broadcast gives word 21, pause gives word 22, multicast gives word 23. By flag (tx_err): bit 0 (underrun) gives word 24, and bits 1 to 7 (collision, abort-collision, multi-collision, single-collision, excessive defer, defer, late collision) give words 35 to 41. By size bin (tx_bin): codes 0 to 5 give words 25 to 30, code 6 gives word 31 (max size), and code 7 gives word 32 (oversize).
- R4: There are three 64-bit byte totals, each with its low word at the lower address and a carry from the low word into the high word. Words 15/16 add rx_len when rx_err is zero. Words 17/18 add rx_len when any rx_err bit is set. Words 33/34 add tx_len on every transmit event.
- R5: Event counters stop at 2^EVT_W-1 and byte totals stop at 2^BYTE_W-1. Neither wraps.
- R6: The module-enable register is at 0x0034. It resets to zero and reads back the word last written to it. Counters change on events only while its bit 0 is 1.
- R7: The control register is at 0x0030. A write while idle with bit 0 (flush) and bit 31 (busy) both set clears every counter of every port. Bit 31 then reads 1 for exactly 42 consecutive cycles and afterwards reads 0. All other control bits read 0.
- R8: A control write that lacks either bit 0 or bit 31 has no effect on the counters or on busy.
- R9: Events presented while busy is set are not counted.
- R10: When an event and a read of the affected word occur in the same cycle, the read returns the value from before the event, and the event is visible to the next read.
- R11: After reset every counter, the busy bit and the enable register read zero.
- R12: Writes into a counter window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| rx_valid | input | NUM_PORTS | Receive event strobe per port |
| rx_cls | input | 2*NUM_PORTS | Receive frame class per port |
| rx_bin | input | 3*NUM_PORTS | Receive size bin per port |
| rx_err | input | 7*NUM_PORTS | Receive error flags per port |
| rx_len | input | LEN_W*NUM_PORTS | Receive frame byte count per port |
| tx_valid | input | NUM_PORTS | Transmit event strobe per port |
| tx_cls | input | 2*NUM_PORTS | Transmit frame class per port |
| tx_bin | input | 3*NUM_PORTS | Transmit size bin per port |
| tx_err | input | 8*NUM_PORTS | Transmit underrun and collision flags per port |
| tx_len | input | LEN_W*NUM_PORTS | Transmit frame byte count per port |

## Verification
A wrong counter value is invisible until software reads that exact word, so the bench sweeps every word of every window after each phase. Any stray increment, wrong word mapping or lost carry shows up as one mismatching word at the next sweep. A flush walker that runs too long or too short shows up on the very next control read as a busy run of the wrong length. A walker that skips a word leaves a nonzero value that the sweep after the flush reports. A gating fault, meaning counting while disabled or while busy, appears as extra counts in the first sweep after the gated interval.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned CNT_WORDS = 42;
    localparam int unsigned WIN_WORDS = 44;
    localparam int unsigned IDX_W     = 6;
    localparam int unsigned RX_ERR_W  = 7;
    localparam int unsigned TX_ERR_W  = 8;

    // word positions inside one port window (software decodes these)
    localparam int unsigned RX_BCAST    = 0;
    localparam int unsigned RX_PAUSE    = 1;
    localparam int unsigned RX_MCAST    = 2;
    localparam int unsigned RX_FCS      = 3;
    localparam int unsigned RX_BIN0     = 7;
    localparam int unsigned RX_MAX      = 13;
    localparam int unsigned RX_LONG     = 14;
    localparam int unsigned RX_GOOD_LO  = 15;
    localparam int unsigned RX_BAD_LO   = 17;
    localparam int unsigned RX_OVF      = 19;
    localparam int unsigned RX_FILT     = 20;
    localparam int unsigned TX_BCAST    = 21;
    localparam int unsigned TX_PAUSE    = 22;
    localparam int unsigned TX_MCAST    = 23;
    localparam int unsigned TX_UNDER    = 24;
    localparam int unsigned TX_BIN0     = 25;
    localparam int unsigned TX_MAX      = 31;
    localparam int unsigned TX_OVER     = 32;
    localparam int unsigned TX_BYTES_LO = 33;
    localparam int unsigned TX_COL0     = 35;

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_BCAST = 2'd1,
        CLS_MCAST = 2'd2,
        CLS_PAUSE = 2'd3
    } frame_cls_e;

    typedef logic [CNT_WORDS-1:0][WORD_W-1:0] bank_words_t;
endpackage

// File: rtl/stat_flush_ctl.sv
module stat_flush_ctl
    import stat_pkg::*;
#(
    parameter int unsigned N_WORDS = CNT_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } flush_st_t;

    flush_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign idx  = st_q.idx;

    // independent count of busy cycles, used only by the check below
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (busy)   run_q <= run_q + 8'd1;
        else             run_q <= '0;
    end

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 8'(N_WORDS));
endmodule

// File: rtl/stat_port_bank.sv
module stat_port_bank
    import stat_pkg::*;
#(
    parameter int unsigned EVT_W  = 32,
    parameter int unsigned BYTE_W = 64,
    parameter int unsigned LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    input  logic                rx_valid,
    input  logic [1:0]          rx_cls,
    input  logic [2:0]          rx_bin,
    input  logic [RX_ERR_W-1:0] rx_err,
    input  logic [LEN_W-1:0]    rx_len,
    input  logic                tx_valid,
    input  logic [1:0]          tx_cls,
    input  logic [2:0]          tx_bin,
    input  logic [TX_ERR_W-1:0] tx_err,
    input  logic [LEN_W-1:0]    tx_len,
    output bank_words_t         words
);
    localparam logic [WORD_W-1:0] EVT_MAX  = WORD_W'((64'd1 << EVT_W) - 64'd1);
    localparam logic [63:0]       BYTE_MAX = (BYTE_W >= 64) ? '1 : ((64'd1 << BYTE_W) - 64'd1);

    typedef struct packed {
        bank_words_t w;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [CNT_WORDS-1:0] hit;

    function automatic logic [63:0] sat_add(input logic [63:0] acc, input logic [LEN_W-1:0] len);
        logic [64:0] sum;
        sum = {1'b0, acc} + 65'(len);
        if (sum[64] || (sum[63:0] > BYTE_MAX)) return BYTE_MAX;
        return sum[63:0];
    endfunction

    // which single-word counters this cycle's events touch
    always_comb begin
        hit = '0;
        if (rx_valid) begin
            case (rx_cls)
                CLS_BCAST: hit[RX_BCAST] = 1'b1;
                CLS_MCAST: hit[RX_MCAST] = 1'b1;
                CLS_PAUSE: hit[RX_PAUSE] = 1'b1;
                default:   ;
            endcase
            for (int i = 0; i < 4; i++) hit[RX_FCS + i] = rx_err[i];
            hit[RX_LONG] = rx_err[4];
            hit[RX_OVF]  = rx_err[5];
            hit[RX_FILT] = rx_err[6];
            for (int b = 0; b < 6; b++)
                if (rx_bin == 3'(b)) hit[RX_BIN0 + b] = 1'b1;
            if (rx_bin == 3'd6) hit[RX_MAX] = 1'b1;
        end
        if (tx_valid) begin
            case (tx_cls)
                CLS_BCAST: hit[TX_BCAST] = 1'b1;
                CLS_MCAST: hit[TX_MCAST] = 1'b1;
                CLS_PAUSE: hit[TX_PAUSE] = 1'b1;
                default:   ;
            endcase
            hit[TX_UNDER] = tx_err[0];
            for (int i = 1; i < TX_ERR_W; i++) hit[TX_COL0 + i - 1] = tx_err[i];
            for (int b = 0; b < 6; b++)
                if (tx_bin == 3'(b)) hit[TX_BIN0 + b] = 1'b1;
            if (tx_bin == 3'd6) hit[TX_MAX]  = 1'b1;
            if (tx_bin == 3'd7) hit[TX_OVER] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            for (int w = 0; w < CNT_WORDS; w++)
                if (clr_idx == IDX_W'(w)) st_d.w[w] = '0;
        end else if (cnt_en) begin
            for (int w = 0; w < CNT_WORDS; w++)
                if (hit[w] && (st_q.w[w] != EVT_MAX)) st_d.w[w] = st_q.w[w] + 32'd1;
            if (rx_valid) begin
                if (rx_err == '0)
                    {st_d.w[RX_GOOD_LO+1], st_d.w[RX_GOOD_LO]} =
                        sat_add({st_q.w[RX_GOOD_LO+1], st_q.w[RX_GOOD_LO]}, rx_len);
                else
                    {st_d.w[RX_BAD_LO+1], st_d.w[RX_BAD_LO]} =
                        sat_add({st_q.w[RX_BAD_LO+1], st_q.w[RX_BAD_LO]}, rx_len);
            end
            if (tx_valid)
                {st_d.w[TX_BYTES_LO+1], st_d.w[TX_BYTES_LO]} =
                    sat_add({st_q.w[TX_BYTES_LO+1], st_q.w[TX_BYTES_LO]}, tx_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.w;

    assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w[RX_BCAST] == EVT_MAX && !clr_en) |=> st_q.w[RX_BCAST] == EVT_MAX);

    assert_gated_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr_en) |=> $stable(st_q));

    assert_bytes_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> {st_q.w[TX_BYTES_LO+1], st_q.w[TX_BYTES_LO]} >=
                    $past({st_q.w[TX_BYTES_LO+1], st_q.w[TX_BYTES_LO]}));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
    import stat_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 7,
    parameter int unsigned EVT_W     = 32,
    parameter int unsigned BYTE_W    = 64,
    parameter int unsigned LEN_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [15:0]                   reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_PORTS-1:0]          rx_valid,
    input  logic [2*NUM_PORTS-1:0]        rx_cls,
    input  logic [3*NUM_PORTS-1:0]        rx_bin,
    input  logic [RX_ERR_W*NUM_PORTS-1:0] rx_err,
    input  logic [LEN_W*NUM_PORTS-1:0]    rx_len,
    input  logic [NUM_PORTS-1:0]          tx_valid,
    input  logic [2*NUM_PORTS-1:0]        tx_cls,
    input  logic [3*NUM_PORTS-1:0]        tx_bin,
    input  logic [TX_ERR_W*NUM_PORTS-1:0] tx_err,
    input  logic [LEN_W*NUM_PORTS-1:0]    tx_len
);
    localparam logic [15:0] CTRL_ADDR = 16'h0030;
    localparam logic [15:0] EN_ADDR   = 16'h0034;
    localparam logic [3:0]  WIN_PAGE  = 4'h1;
    localparam int unsigned FLUSH_BIT = 0;
    localparam int unsigned BUSY_BIT  = 31;

    typedef struct packed {
        logic [31:0] en_word;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t          st_d, st_q;
    bank_words_t      bank_w [NUM_PORTS];
    bank_words_t      sel_bank;
    logic             sel_hit;
    logic             busy;
    logic [IDX_W-1:0] clr_idx;
    logic             flush_start;
    logic             cnt_en;
    logic [31:0]      rd_word;

    assign flush_start = reg_wr && (reg_addr == CTRL_ADDR)
                         && reg_wdata[FLUSH_BIT] && reg_wdata[BUSY_BIT];
    assign cnt_en      = st_q.en_word[0] && !busy;

    stat_flush_ctl #(.N_WORDS(CNT_WORDS)) i_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .start (flush_start),
        .busy  (busy),
        .idx   (clr_idx)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        stat_port_bank #(.EVT_W(EVT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en   (cnt_en),
            .clr_en   (busy),
            .clr_idx  (clr_idx),
            .rx_valid (rx_valid[p]),
            .rx_cls   (rx_cls[2*p +: 2]),
            .rx_bin   (rx_bin[3*p +: 3]),
            .rx_err   (rx_err[RX_ERR_W*p +: RX_ERR_W]),
            .rx_len   (rx_len[LEN_W*p +: LEN_W]),
            .tx_valid (tx_valid[p]),
            .tx_cls   (tx_cls[2*p +: 2]),
            .tx_bin   (tx_bin[3*p +: 3]),
            .tx_err   (tx_err[TX_ERR_W*p +: TX_ERR_W]),
            .tx_len   (tx_len[LEN_W*p +: LEN_W]),
            .words    (bank_w[p])
        );

        assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy) |-> bank_w[p] == '0);
    end

    // read decode: global registers, then per-port windows
    always_comb begin
        sel_bank = '0;
        sel_hit  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr[11:8] == 4'(p)) begin
                sel_bank = bank_w[p];
                sel_hit  = 1'b1;
            end
        end
        rd_word = '0;
        if (reg_addr == CTRL_ADDR) begin
            rd_word[BUSY_BIT] = busy;
        end else if (reg_addr == EN_ADDR) begin
            rd_word = st_q.en_word;
        end else if ((reg_addr[15:12] == WIN_PAGE) && (reg_addr[1:0] == 2'b00) && sel_hit
                     && (reg_addr[7:2] < IDX_W'(CNT_WORDS))) begin
            rd_word = sel_bank[reg_addr[7:2]];
        end
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && (reg_addr == EN_ADDR)) st_d.en_word = reg_wdata;
        if (reg_rd) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
endmodule

// File: tb/test_stat_counter_bank.sv
`timescale 1ns/1ps
module test_stat_counter_bank;
    localparam int NP    = 7;
    localparam int EVTW  = 8;
    localparam int LENW  = 16;
    localparam int NCW   = 42;
    localparam logic [31:0] EMAX = 32'd255;
    localparam logic [15:0] A_CTRL = 16'h0030;
    localparam logic [15:0] A_EN   = 16'h0034;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] rx_valid = '0, tx_valid = '0;
    logic [2*NP-1:0] rx_cls = '0, tx_cls = '0;
    logic [3*NP-1:0] rx_bin = '0, tx_bin = '0;
    logic [7*NP-1:0] rx_err = '0;
    logic [8*NP-1:0] tx_err = '0;
    logic [LENW*NP-1:0] rx_len = '0, tx_len = '0;

    int n_cmp = 0, n_bad = 0;
    logic en_m = 1'b0;
    logic [31:0] exp_w [NP][NCW];

    always #10 clk = ~clk;

    stat_counter_bank #(.NUM_PORTS(NP), .EVT_W(EVTW), .BYTE_W(64), .LEN_W(LENW)) i_stat_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_cls(rx_cls), .rx_bin(rx_bin), .rx_err(rx_err), .rx_len(rx_len),
        .tx_valid(tx_valid), .tx_cls(tx_cls), .tx_bin(tx_bin), .tx_err(tx_err), .tx_len(tx_len));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int w);
        if (w >= NCW) return "R1";
        if (w == 15 || w == 16 || w == 17 || w == 18 || w == 33 || w == 34) return "R4";
        if (w <= 20) return "R2";
        return "R3";
    endfunction

    task automatic bump(input int p, input int w);
        if (exp_w[p][w] != EMAX) exp_w[p][w] = exp_w[p][w] + 1;
    endtask

    task automatic add_bytes(input int p, input int w, input logic [15:0] len);
        logic [63:0] v;
        v = {exp_w[p][w+1], exp_w[p][w]} + 64'(len);
        exp_w[p][w] = v[31:0];
        exp_w[p][w+1] = v[63:32];
    endtask

    task automatic model_rx(input int p, input logic [1:0] c, input logic [2:0] b,
                            input logic [6:0] e, input logic [15:0] len);
        if (c == 2'd1) bump(p, 0);
        if (c == 2'd3) bump(p, 1);
        if (c == 2'd2) bump(p, 2);
        for (int i = 0; i < 4; i++) if (e[i]) bump(p, 3 + i);
        if (e[4]) bump(p, 14);
        if (e[5]) bump(p, 19);
        if (e[6]) bump(p, 20);
        if (b < 3'd6) bump(p, 7 + int'(b));
        else if (b == 3'd6) bump(p, 13);
        if (e == '0) add_bytes(p, 15, len); else add_bytes(p, 17, len);
    endtask

    task automatic model_tx(input int p, input logic [1:0] c, input logic [2:0] b,
                            input logic [7:0] e, input logic [15:0] len);
        if (c == 2'd1) bump(p, 21);
        if (c == 2'd3) bump(p, 22);
        if (c == 2'd2) bump(p, 23);
        if (e[0]) bump(p, 24);
        for (int i = 1; i < 8; i++) if (e[i]) bump(p, 34 + i);
        if (b < 3'd6) bump(p, 25 + int'(b));
        else if (b == 3'd6) bump(p, 31);
        else bump(p, 32);
        add_bytes(p, 33, len);
    endtask

    task automatic idle_events();
        rx_valid = '0; tx_valid = '0; rx_err = '0; tx_err = '0;
    endtask

    // one cycle of random events on all ports; counted in the model only if 'counted'
    task automatic rand_cycle(input logic counted);
        for (int p = 0; p < NP; p++) begin
            logic rv, tv; logic [1:0] rc, tc; logic [2:0] rb, tb;
            logic [6:0] re; logic [7:0] te; logic [15:0] rl, tl;
            rv = 1'($urandom % 2); tv = 1'($urandom % 2);
            rc = 2'($urandom); tc = 2'($urandom);
            rb = 3'($urandom); tb = 3'($urandom);
            re = '0; te = '0;
            for (int i = 0; i < 7; i++) re[i] = ($urandom % 8) == 0;
            for (int i = 0; i < 8; i++) te[i] = ($urandom % 8) == 0;
            rl = 16'($urandom); tl = 16'($urandom);
            rx_valid[p] = rv; tx_valid[p] = tv;
            rx_cls[2*p +: 2] = rc; tx_cls[2*p +: 2] = tc;
            rx_bin[3*p +: 3] = rb; tx_bin[3*p +: 3] = tb;
            rx_err[7*p +: 7] = re; tx_err[8*p +: 8] = te;
            rx_len[16*p +: 16] = rl; tx_len[16*p +: 16] = tl;
            if (counted && en_m) begin
                if (rv) model_rx(p, rc, rb, re, rl);
                if (tv) model_tx(p, tc, tb, te, tl);
            end
        end
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [15:0] waddr(input int p, input int w);
        return 16'h1000 + 16'(p * 256) + 16'(w * 4);
    endfunction

    task automatic sweep(input string over);
        logic [31:0] d;
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < 44; w++) begin
                reg_read(waddr(p, w), d);
                chk((over != "") ? over : tag_of(w), d, (w < NCW) ? exp_w[p][w] : 32'd0);
            end
    endtask

    task automatic clear_model();
        for (int p = 0; p < NP; p++) for (int w = 0; w < NCW; w++) exp_w[p][w] = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R7: watchdog expired, actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d, old;
        int busy_cnt;
        void'($urandom(32'd4242));
        clear_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        reg_read(A_CTRL, d); chk("R11", d, 32'd0);
        reg_read(A_EN, d);   chk("R11", d, 32'd0);
        sweep("R11");
        // R1 unmapped addresses
        reg_read(16'h1700, d); chk("R1", d, 32'd0);
        reg_read(16'h1102, d); chk("R1", d, 32'd0);
        reg_read(16'h2000, d); chk("R1", d, 32'd0);

        // R6 disabled: events ignored
        repeat (50) rand_cycle(1'b1);
        idle_events();
        sweep("R6");

        reg_write(A_EN, 32'h0000_0001); en_m = 1'b1;
        reg_read(A_EN, d); chk("R6", d, 32'h1);

        // R2 R3 R4 random traffic
        repeat (1500) rand_cycle(1'b1);
        idle_events();
        sweep("");

        // R5 saturation on port 0 receive broadcast
        for (int i = 0; i < 300; i++) begin
            rx_valid[0] = 1'b1; rx_cls[1:0] = 2'd1; rx_bin[2:0] = 3'd7; rx_err[6:0] = '0; rx_len[15:0] = 16'd0;
            model_rx(0, 2'd1, 3'd7, 7'd0, 16'd0);
            @(negedge clk);
        end
        idle_events();
        reg_read(waddr(0, 0), d); chk("R5", d, EMAX);

        // R12 write to a counter word is ignored
        reg_write(waddr(2, 0), 32'hFFFF_FFFF);
        reg_read(waddr(2, 0), d); chk("R12", d, exp_w[2][0]);

        // R10 read and event on the same cycle
        old = exp_w[1][19];
        reg_rd = 1'b1; reg_addr = waddr(1, 19);
        rx_valid[1] = 1'b1; rx_cls[3:2] = 2'd0; rx_bin[5:3] = 3'd7; rx_err[13:7] = 7'b0100000; rx_len[31:16] = 16'd10;
        model_rx(1, 2'd0, 3'd7, 7'b0100000, 16'd10);
        @(negedge clk);
        reg_rd = 1'b0; idle_events();
        chk("R10", reg_rdata, old);
        reg_read(waddr(1, 19), d); chk("R10", d, exp_w[1][19]);

        // R6 disable mid-run
        reg_write(A_EN, 32'h0000_0000); en_m = 1'b0;
        repeat (30) rand_cycle(1'b1);
        idle_events();
        reg_read(A_EN, d); chk("R6", d, 32'h0);
        sweep("R6");
        reg_write(A_EN, 32'h0000_0001); en_m = 1'b1;

        // R8 incomplete flush commands
        reg_write(A_CTRL, 32'h0000_0001);
        reg_read(A_CTRL, d); chk("R8", d, 32'h0);
        reg_write(A_CTRL, 32'h8000_0000);
        reg_read(A_CTRL, d); chk("R8", d, 32'h0);
        reg_read(waddr(3, 21), d); chk("R8", d, exp_w[3][21]);

        // R7 R9 flush with events during busy
        reg_write(A_CTRL, 32'h8000_0001);
        clear_model();
        busy_cnt = 0;
        reg_rd = 1'b1; reg_addr = A_CTRL;
        for (int i = 0; i < 42; i++) begin
            rand_cycle(1'b0);
            if (reg_rdata[31]) busy_cnt++;
        end
        idle_events();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (reg_rdata[31]) busy_cnt++;
        end
        reg_rd = 1'b0;
        chk("R7", 32'(busy_cnt), 32'd42);
        reg_read(A_CTRL, d); chk("R7", d, 32'h0);
        sweep("R9");

        // R4 carry into the high word of the byte totals
        for (int i = 0; i < 65600; i++) begin
            rx_valid[5] = 1'b1; rx_cls[11:10] = 2'd0; rx_bin[17:15] = 3'd7; rx_err[41:35] = '0; rx_len[95:80] = 16'hFFFF;
            tx_valid[5] = 1'b1; tx_cls[11:10] = 2'd0; tx_bin[17:15] = 3'd0; tx_err[47:40] = '0; tx_len[95:80] = 16'hFFFF;
            model_rx(5, 2'd0, 3'd7, 7'd0, 16'hFFFF);
            model_tx(5, 2'd0, 3'd0, 8'd0, 16'hFFFF);
            @(negedge clk);
        end
        idle_events();
        reg_read(waddr(5, 16), d); chk("R4", d, 32'd1);
        reg_read(waddr(5, 34), d); chk("R4", d, 32'd1);
        sweep("");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule